// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the module clock. A single configuration word holds two divisor fields and a selector bit. In linear mode the serial clock runs at the module clock divided by 2×(N+1). In exponential mode it runs at the module clock divided by 2^E. The divider only runs while the shift engine holds its burst request high and the bus is enabled. At all other times the serial clock sits at the idle level given by the clock polarity input.

Alongside the serial clock the block issues two one-cycle strobes. A leading strobe marks the module-clock cycle in which the serial clock leaves its idle level. A trailing strobe marks the cycle in which it returns. The shift engine uses them to shift and sample. Writing the configuration word or starting a new burst restarts the divider from the beginning of a half period, so the first edge of a burst always comes a full half period after the start.

Top module: `spi_sck_divider`

## Requirements
- R1: After reset the configuration word reads 0, the serial clock is at the idle level, and neither strobe is asserted.
- R2: The configuration word is loaded from `cfg_wdata` on a clock with `cfg_we` high and keeps its value otherwise. Bits [7:0] hold the linear divisor N, bits [11:8] hold the exponent E, and bit 12 selects linear mode when 1 and exponential mode when 0.
- R3: In linear mode each half period of the serial clock lasts N+1 module clocks, giving a full period of 2×(N+1). The exponent field has no effect in this mode.
- R4: In exponential mode each half period lasts 2^(E-1) module clocks, giving a full period of 2^E. E=0 behaves as E=1, and the linear field has no effect in this mode.
- R5: The leading strobe is high for exactly the one module clock in which the serial clock first shows its active level. The trailing strobe is high for exactly the one clock in which it first shows the idle level again. The two strobes never coincide and they alternate, starting with a leading strobe.
- R6: While `run` or `bus_en` is low, the serial clock equals `cpol` and both strobes stay low.
- R7: A configuration write, or a rising edge of `run`, returns the serial clock to idle on the next clock without a strobe. The first leading strobe then appears H clocks later, where H is the half-period length.
- R8: With `cpol`=1 the serial clock idles high and is low during the active half. With `cpol`=0 it idles low.
- R9: Raising `bus_en` while `run` is already high keeps the serial clock at idle for H-1 further clocks. The first leading edge follows on the H-th clock, with no earlier glitch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 13 | Configuration word to write (N, E, mode bit) |
| cfg_q | output | 13 | Current configuration word |
| bus_en | input | 1 | Bus enable; the serial clock only toggles while high |
| run | input | 1 | Burst request from the shift engine; a rising edge starts a burst |
| cpol | input | 1 | Clock polarity: idle level of the serial clock |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the serial clock's leading edge |
| trail_stb | output | 1 | One-cycle strobe on the serial clock's trailing edge |

## Verification
The bench builds the block with its default widths: an 8-bit linear field and a 4-bit exponent. This puts the extremes within reach. It covers a half period of one module clock (N=0, E=0, E=1), a 256-clock half period from both the largest N and E=9, and the longest exponential half period of 16384 clocks at E=15. Vectors set the unused field to a non-zero value to show that it is ignored. Directed cases cover a restart in the middle of an active half, and enabling the bus with a burst already pending.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

    localparam int DEF_LIN_W = 8;
    localparam int DEF_EXP_W = 4;

    typedef enum logic {
        DIV_EXP = 1'b0,
        DIV_LIN = 1'b1
    } div_mode_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Width that holds the largest half period minus one in either mode.
    function automatic int half_width(input int lin_w, input int exp_w);
        return max_int(lin_w + 1, (1 << exp_w) - 1);
    endfunction

endpackage

// File: rtl/spi_div_cfg_reg.sv
module spi_div_cfg_reg
    import spi_div_pkg::*;
#(
    parameter int LIN_W = DEF_LIN_W,
    parameter int EXP_W = DEF_EXP_W,
    localparam int CFG_W = LIN_W + EXP_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] q,
    output logic [LIN_W-1:0] lin_n,
    output logic [EXP_W-1:0] exp_e,
    output div_mode_e        mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

    assign lin_n = q[LIN_W-1:0];
    assign exp_e = q[LIN_W+EXP_W-1:LIN_W];
    assign mode  = div_mode_e'(q[CFG_W-1]);

    p_cfg_load_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(wdata)));

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/spi_div_half_calc.sv
module spi_div_half_calc
    import spi_div_pkg::*;
#(
    parameter int LIN_W = DEF_LIN_W,
    parameter int EXP_W = DEF_EXP_W,
    localparam int HALF_W = half_width(LIN_W, EXP_W)
) (
    input  logic [LIN_W-1:0]  lin_n,
    input  logic [EXP_W-1:0]  exp_e,
    input  div_mode_e         mode,
    output logic [HALF_W-1:0] half_m1
);

    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

    logic [EXP_W-1:0]  e_eff;
    logic [HALF_W-1:0] exp_half;
    logic [HALF_W-1:0] lin_half;

    // The smallest exponential division is two, so E=0 folds onto E=1.
    assign e_eff    = (exp_e == '0) ? EXP_W'(1) : exp_e;
    assign exp_half = (ONE << (e_eff - EXP_W'(1))) - ONE;
    assign lin_half = {{(HALF_W-LIN_W){1'b0}}, lin_n};

    always_comb begin
        unique case (mode)
            DIV_LIN: half_m1 = lin_half;
            default: half_m1 = exp_half;
        endcase
    end

endmodule

// File: rtl/spi_div_phase_gen.sv
module spi_div_phase_gen #(
    parameter int HALF_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              restart,
    input  logic [HALF_W-1:0] half_m1,
    output logic              phase,
    output logic              lead,
    output logic              trail
);

    logic [HALF_W-1:0] cnt;
    logic              wrap;

    assign wrap = (cnt == half_m1);

    always_ff @(posedge clk) begin
        if (rst || restart || !active) begin
            cnt   <= '0;
            phase <= 1'b0;
            lead  <= 1'b0;
            trail <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= ~phase;
            lead  <= ~phase;
            trail <= phase;
        end else begin
            cnt   <= cnt + HALF_W'(1);
            lead  <= 1'b0;
            trail <= 1'b0;
        end
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (cnt <= half_m1));

    p_restart_idle_r7: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!phase && !lead && !trail));

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(lead && trail));

    p_lead_active_r5: assert property (@(posedge clk) disable iff (rst)
        lead |-> (phase && $rose(phase)));

    p_trail_idle_r5: assert property (@(posedge clk) disable iff (rst)
        trail |-> (!phase && $fell(phase)));

endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
    import spi_div_pkg::*;
#(
    parameter int LIN_W = DEF_LIN_W,
    parameter int EXP_W = DEF_EXP_W,
    localparam int CFG_W  = LIN_W + EXP_W + 1,
    localparam int HALF_W = half_width(LIN_W, EXP_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    input  logic             bus_en,
    input  logic             run,
    input  logic             cpol,
    output logic             sck,
    output logic             lead_stb,
    output logic             trail_stb
);

    logic [LIN_W-1:0]  lin_n;
    logic [EXP_W-1:0]  exp_e;
    div_mode_e         mode;
    logic [HALF_W-1:0] half_m1;
    logic              run_q;
    logic              restart;
    logic              active;
    logic              phase;

    spi_div_cfg_reg #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q),
        .lin_n (lin_n),
        .exp_e (exp_e),
        .mode  (mode)
    );

    spi_div_half_calc #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_half (
        .lin_n   (lin_n),
        .exp_e   (exp_e),
        .mode    (mode),
        .half_m1 (half_m1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else begin
            run_q <= run;
        end
    end

    assign restart = cfg_we || (run && !run_q);
    assign active  = run && bus_en;

    spi_div_phase_gen #(.HALF_W(HALF_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .restart (restart),
        .half_m1 (half_m1),
        .phase   (phase),
        .lead    (lead_stb),
        .trail   (trail_stb)
    );

    assign sck = phase ^ cpol;

    p_idle_level_r6: assert property (@(posedge clk) disable iff (rst)
        !(run && bus_en) |=> (!lead_stb && !trail_stb && (sck == cpol)));

    p_polarity_r8: assert property (@(posedge clk) disable iff (rst)
        lead_stb |-> (sck == !cpol));

endmodule

// File: tb/sim_spi_sck_divider.sv
module sim_spi_sck_divider;

    localparam int CFG_W = 13;
    localparam int LIMIT = 40000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [CFG_W-1:0] cfg_q;
    logic             bus_en = 1'b0;
    logic             run = 1'b0;
    logic             cpol = 1'b0;
    logic             sck;
    logic             lead_stb;
    logic             trail_stb;

    int applied = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    spi_sck_divider u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q),
        .bus_en    (bus_en),
        .run       (run),
        .cpol      (cpol),
        .sck       (sck),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    // mode (1 = linear), N, E, cpol, expected half period in module clocks
    typedef struct packed {
        logic        lin;
        logic [7:0]  n;
        logic [3:0]  e;
        logic        pol;
        logic [15:0] half;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'd0,   4'd0,  1'b0, 16'd1},
        '{1'b1, 8'd3,   4'd7,  1'b1, 16'd4},
        '{1'b1, 8'd255, 4'd0,  1'b0, 16'd256},
        '{1'b0, 8'd0,   4'd0,  1'b0, 16'd1},
        '{1'b0, 8'd0,   4'd1,  1'b1, 16'd1},
        '{1'b0, 8'd0,   4'd2,  1'b0, 16'd2},
        '{1'b0, 8'hAA,  4'd5,  1'b1, 16'd16},
        '{1'b0, 8'd0,   4'd9,  1'b0, 16'd256},
        '{1'b0, 8'd0,   4'd15, 1'b0, 16'd16384}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        applied++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [CFG_W-1:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Counts falling edges until the chosen strobe is seen.
    task automatic wait_stb(input bit want_lead, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(want_lead ? lead_stb : trail_stb) && n < LIMIT);
    endtask

    task automatic measure(input int h, input logic pol, input string req);
        int n;
        wait_stb(1'b1, n);
        check(n == h, {req, " first lead delay"}, n, h);
        check(sck == !pol, "R8 active level after lead", sck, !pol);
        wait_stb(1'b0, n);
        check(n == h, {req, " lead to trail"}, n, h);
        check(sck == pol, "R5 idle level after trail", sck, pol);
        wait_stb(1'b1, n);
        check(n == h, {req, " trail to lead"}, n, h);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        int n;
        logic [CFG_W-1:0] w;
        bit stray;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cfg_q == '0, "R1 cfg after reset", int'(cfg_q), 0);
        check(sck == 1'b0 && !lead_stb && !trail_stb, "R1 idle after reset", sck, 0);
        bus_en = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            vec_t v = VECS[i];
            cpol = v.pol;
            w = {v.lin, v.e, v.n};
            write_cfg(w);
            check(cfg_q == w, "R2 cfg load", int'(cfg_q), int'(w));
            repeat (2) @(negedge clk);
            check(cfg_q == w, "R2 cfg hold", int'(cfg_q), int'(w));
            check(sck == v.pol && !lead_stb, "R6 idle while run low", sck, v.pol);
            run = 1'b1;
            @(negedge clk);
            check(sck == v.pol, "R7 idle after run rises", sck, v.pol);
            measure(int'(v.half), v.pol, v.lin ? "R3 linear" : "R4 exponential");
            run = 1'b0;
            @(negedge clk);
            check(sck == v.pol && !lead_stb && !trail_stb, "R6 idle after run falls", sck, v.pol);
        end

        // R7: configuration write in the middle of an active half
        cpol = 1'b0;
        write_cfg({1'b1, 4'd0, 8'd3});
        run = 1'b1;
        wait_stb(1'b1, n);
        @(negedge clk);
        check(sck == 1'b1, "R7 active before restart", sck, 1);
        cfg_we = 1'b1;
        cfg_wdata = {1'b1, 4'd0, 8'd3};
        @(negedge clk);
        cfg_we = 1'b0;
        check(sck == 1'b0 && !lead_stb && !trail_stb, "R7 idle after restart", sck, 0);
        wait_stb(1'b1, n);
        check(n == 4, "R7 lead after restart", n, 4);

        // R6/R9: burst pending with bus disabled, then enable
        run = 1'b0;
        bus_en = 1'b0;
        @(negedge clk);
        run = 1'b1;
        stray = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (sck != 1'b0 || lead_stb || trail_stb) stray = 1'b1;
        end
        check(!stray, "R6 idle while bus disabled", stray, 0);
        bus_en = 1'b1;
        stray = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (!lead_stb && sck != 1'b0) stray = 1'b1;
        end while (!lead_stb && n < LIMIT);
        check(!stray, "R9 no glitch on enable", stray, 0);
        check(n == 4, "R9 first lead after enable", n, 4);
        run = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule